// File: doc/BRIEF.md
# SPI Register-Access Slave with Burst Transfers

This block connects an external SPI master to an on-chip register file. The three SPI inputs (serial clock, active-low chip select and serial data in) are brought into the system clock domain through two-flop synchronisers. Every edge decision is then made in the system clock domain. A frame opens when chip select goes low. It begins with an eight-bit header: a seven-bit register address followed by a direction flag. After the header come one or more sixteen-bit data words. The register address steps forward by one after each completed word, so a single header can cover a run of consecutive registers.

In a write frame, each completed word produces a one-cycle write strobe, with the word's address and data, towards the register file. In a read frame, the block requests the addressed register as soon as the header is complete. The register file returns data one system cycle after the request, and the block loads it into a transmit shifter that drives the serial output. The serial output has its own enable, which is low whenever chip select is high, so the pad can be tri-stated.

Top module: `spi_regport_slave`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges. The first seven bits of a frame form the register address, most significant bit first. The eighth bit is the direction flag: 1 means read, 0 means write.
- R2: In a write frame, once the sixteenth bit of a word has been sampled, `reg_wr_o` pulses high for exactly one system cycle. During that cycle `reg_addr_o` holds the word's address and `reg_wdata_o` holds the sixteen bits, first-received bit in bit 15.
- R3: Within a burst the address rises by one after each completed word, and it wraps from 127 to 0.
- R4: A partial header or a partial data word left when chip select rises produces no strobe.
- R5: In a read frame, one system cycle after the direction flag is sampled, `reg_rd_o` pulses for one cycle with the header address on `reg_addr_o`. `reg_rdata_i` is taken in the following cycle.
- R6: Read data is shifted out most significant bit first. Bit 15 is on `miso_o` before the first rising serial-clock edge of the word, and each following bit appears after a falling serial-clock edge.
- R7: At the end of each word of a read frame, the block fetches the next address (again wrapping 127 to 0). A burst therefore returns consecutive registers without gaps.
- R8: `miso_oe_o` is low within three system cycles of chip select rising and high within three cycles of it falling. `miso_o` is 0 throughout the header.
- R9: A read frame produces no write strobe.
- R10: After reset, `reg_wr_o`, `reg_rd_o` and `miso_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI serial data from master |
| miso_o | output | 1 | SPI serial data to master |
| miso_oe_o | output | 1 | Output enable for miso_o pad |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read request |
| reg_addr_o | output | 7 | Register address for strobe or request |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data, valid one cycle after reg_rd_o |

## Verification
Write frames are tried as a single word, as a four-word burst and as a burst that crosses address 127. Together these separate a correct address increment from a stuck or non-wrapping counter, and show that each word's data lands at its own address. A write frame that ends with nine stray bits, and a frame cut off partway through its header, show whether incomplete words leak out as strobes. Read frames of one word, four words and a burst across the wrap compare every returned bit with the values written earlier. This exposes late loading of the most significant bit, off-by-one shifting and a wrong prefetch address. Meanwhile the output enable and the write-strobe queue are checked on every clock.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
  parameter int          STAGES  = 2,
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  generate
    for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i[b]};
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= {STAGES{RST_VAL[b]}};
        end else begin
          chain_q <= chain_d;
        end
      end

      assign q_o[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_rp_frame.sv
module spi_rp_frame
  import spi_rp_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          rise_i,
  input  logic          din_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int HCW = $clog2(AW + 1);
  localparam int DCW = $clog2(DW);

  phase_e        phase_q, phase_d;
  logic [HCW-1:0] hcnt_q, hcnt_d;
  logic [DCW-1:0] dcnt_q, dcnt_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [AW-1:0]  cur_q, cur_d;
  logic           rd_q, rd_d;
  logic           wr_en_q, wr_en_d;
  logic           rd_en_q, rd_en_d;
  logic [AW-1:0]  port_addr_q, port_addr_d;
  logic [DW-1:0]  wdata_q, wdata_d;
  logic [DW-1:0]  sh_next;

  assign sh_next = {sh_q[DW-2:0], din_i};

  always_comb begin
    phase_d     = phase_q;
    hcnt_d      = hcnt_q;
    dcnt_d      = dcnt_q;
    sh_d        = sh_q;
    cur_d       = cur_q;
    rd_d        = rd_q;
    wr_en_d     = 1'b0;
    rd_en_d     = 1'b0;
    port_addr_d = port_addr_q;
    wdata_d     = wdata_q;
    if (!cs_act_i) begin
      phase_d = PH_HDR;
      hcnt_d  = '0;
      dcnt_d  = '0;
    end else if (rise_i) begin
      sh_d = sh_next;
      if (phase_q == PH_HDR) begin
        if (hcnt_q == HCW'(AW)) begin
          cur_d   = sh_q[AW-1:0];
          rd_d    = din_i;
          phase_d = PH_DATA;
          dcnt_d  = '0;
          if (din_i) begin
            rd_en_d     = 1'b1;
            port_addr_d = sh_q[AW-1:0];
          end
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end else begin
        if (dcnt_q == DCW'(DW - 1)) begin
          dcnt_d = '0;
          cur_d  = cur_q + 1'b1;
          if (rd_q) begin
            rd_en_d     = 1'b1;
            port_addr_d = cur_q + 1'b1;
          end else begin
            wr_en_d     = 1'b1;
            port_addr_d = cur_q;
            wdata_d     = sh_next;
          end
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_HDR;
      hcnt_q      <= '0;
      dcnt_q      <= '0;
      sh_q        <= '0;
      cur_q       <= '0;
      rd_q        <= 1'b0;
      wr_en_q     <= 1'b0;
      rd_en_q     <= 1'b0;
      port_addr_q <= '0;
      wdata_q     <= '0;
    end else begin
      phase_q     <= phase_d;
      hcnt_q      <= hcnt_d;
      dcnt_q      <= dcnt_d;
      sh_q        <= sh_d;
      cur_q       <= cur_d;
      rd_q        <= rd_d;
      wr_en_q     <= wr_en_d;
      rd_en_q     <= rd_en_d;
      port_addr_q <= port_addr_d;
      wdata_q     <= wdata_d;
    end
  end

  assign wr_en_o = wr_en_q;
  assign rd_en_o = rd_en_q;
  assign addr_o  = port_addr_q;
  assign wdata_o = wdata_q;

  // R2
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q);

  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_q |=> !rd_en_q);
endmodule

// File: rtl/spi_rp_tx.sv
module spi_rp_tx #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          rd_req_i,
  input  logic [DW-1:0] ld_data_i,
  output logic          miso_o,
  output logic          oe_o
);
  logic [DW-1:0] sh_q, sh_d;
  logic          pend_q, pend_d;
  logic          load_q;
  logic          oe_q;

  always_comb begin
    sh_d   = sh_q;
    pend_d = pend_q;
    if (!cs_act_i) begin
      sh_d   = '0;
      pend_d = 1'b0;
    end else if (load_q) begin
      sh_d   = ld_data_i;
      pend_d = 1'b0;
    end else if (rise_i) begin
      pend_d = 1'b1;
    end else if (fall_i && pend_q) begin
      sh_d   = {sh_q[DW-2:0], 1'b0};
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      pend_q <= 1'b0;
      load_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      pend_q <= pend_d;
      load_q <= rd_req_i;
      oe_q   <= cs_act_i;
    end
  end

  assign miso_o = sh_q[DW-1];
  assign oe_o   = oe_q;

  // R6
  msb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_q && cs_act_i) |=> (miso_o == $past(ld_data_i[DW-1])));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_i && !load_q && !fall_i) |=> $stable(miso_o));
endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave #(
  parameter int AW          = 7,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          reg_wr_o,
  output logic          reg_rd_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int         NSYNC    = 3;
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync_out;
  logic             sclk_s, csn_s, din_s;
  logic             sclk_prev_q;
  logic             rise, fall, cs_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  assign raw_in = {mosi_i, cs_ni, sclk_i};

  spi_rp_sync #(
    .STAGES (SYNC_STAGES),
    .N      (NSYNC),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign sclk_s = sync_out[0];
  assign csn_s  = sync_out[1];
  assign din_s  = sync_out[2];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
    end
  end

  assign rise   = sclk_s & ~sclk_prev_q;
  assign fall   = ~sclk_s & sclk_prev_q;
  assign cs_act = ~csn_s;

  spi_rp_frame #(
    .AW(AW),
    .DW(DW)
  ) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .cs_act_i(cs_act),
    .rise_i  (rise),
    .din_i   (din_s),
    .wr_en_o (reg_wr_o),
    .rd_en_o (reg_rd_o),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o)
  );

  spi_rp_tx #(
    .DW(DW)
  ) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cs_act_i (cs_act),
    .rise_i   (rise),
    .fall_i   (fall),
    .rd_req_i (reg_rd_o),
    .ld_data_i(reg_rdata_i),
    .miso_o   (miso_o),
    .oe_o     (miso_oe_o)
  );

  // R8
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    csn_s |=> !miso_oe_o);

  // R9
  no_wr_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    reg_rd_o |-> !reg_wr_o);
endmodule

// File: tb/spi_regport_slave_tb.sv
module spi_regport_slave_tb_top;
  localparam int HALF = 10;

  logic        clk;
  logic        rst_n;
  logic        sclk, csn, mosi;
  logic        miso, miso_oe, reg_wr, reg_rd;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;

  logic [15:0] mem     [128];
  logic [15:0] ref_mem [128];
  logic [22:0] exp_wr_q [$];
  logic [6:0]  exp_rd_q [$];
  int          checks, fails;
  int          cs_hi_cnt, cs_lo_cnt;
  logic        done;

  spi_regport_slave dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sclk_i     (sclk),
    .cs_ni      (csn),
    .mosi_i     (mosi),
    .miso_o     (miso),
    .miso_oe_o  (miso_oe),
    .reg_wr_o   (reg_wr),
    .reg_rd_o   (reg_rd),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register file model with one-cycle read latency
  always @(posedge clk) begin
    if (reg_rd) reg_rdata <= mem[reg_addr];
    if (reg_wr) mem[reg_addr] <= reg_wdata;
  end

  // per-clock comparison against the expected strobe queues
  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      if (reg_wr) begin
        if (exp_wr_q.size() == 0) begin
          chk(1'b0, "R4/R9 unexpected write", {25'd0, reg_addr}, 0);
        end else begin
          logic [22:0] e;
          e = exp_wr_q.pop_front();
          chk(reg_addr == e[22:16], "R2/R3 write addr", reg_addr, e[22:16]);
          chk(reg_wdata == e[15:0], "R2 write data", reg_wdata, e[15:0]);
        end
      end
      if (reg_rd) begin
        if (exp_rd_q.size() == 0) begin
          chk(1'b0, "R5 unexpected read", reg_addr, 0);
        end else begin
          logic [6:0] ea;
          ea = exp_rd_q.pop_front();
          chk(reg_addr == ea, "R5/R7 read addr", reg_addr, ea);
        end
      end
      if (csn) begin cs_hi_cnt++; cs_lo_cnt = 0; end
      else begin cs_lo_cnt++; cs_hi_cnt = 0; end
      if (cs_hi_cnt >= 4) chk(miso_oe == 1'b0, "R8 oe low", miso_oe, 0);
      if (cs_lo_cnt >= 4) chk(miso_oe == 1'b1, "R8 oe high", miso_oe, 1);
    end
  end

  function automatic logic [15:0] wpat(input int a, input int w);
    return 16'((a * 613 + w * 4099 + 15450) & 16'hFFFF);
  endfunction

  task automatic send_bit(input logic b, output logic s);
    mosi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    s = miso;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [6:0] a, input logic rd, input int nw, input int extra);
    logic [6:0]  cur;
    logic        s;
    logic [15:0] d;
    cur = a;
    if (rd) begin
      for (int k = 0; k <= nw; k++) exp_rd_q.push_back(7'(a + k));
    end
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      send_bit((i < 7) ? a[6-i] : rd, s);
      chk(s == 1'b0, "R8 header miso", s, 0);
    end
    for (int w = 0; w < nw; w++) begin
      if (!rd) begin
        d = wpat(cur, w);
        exp_wr_q.push_back({cur, d});
        ref_mem[cur] = d;
        for (int j = 0; j < 16; j++) send_bit(d[15-j], s);
      end else begin
        for (int j = 0; j < 16; j++) begin
          send_bit(1'b0, s);
          d[15-j] = s;
        end
        chk(d == ref_mem[cur], "R6/R7 read word", d, ref_mem[cur]);
      end
      cur = cur + 7'd1;
    end
    for (int e = 0; e < extra; e++) send_bit(e[0], s);
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (3 * HALF) @(negedge clk);
    chk(exp_wr_q.size() == 0, "R2/R4 writes drained", exp_wr_q.size(), 0);
    chk(exp_rd_q.size() == 0, "R5/R7 reads drained", exp_rd_q.size(), 0);
  endtask

  // header cut short after a few bits
  task automatic short_frame(input int nbits);
    logic s;
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) send_bit(1'b1, s);
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    cs_hi_cnt = 0; cs_lo_cnt = 0;
    sclk = 1'b0; csn = 1'b1; mosi = 1'b0; rst_n = 1'b0;
    reg_rdata = '0;
    for (int i = 0; i < 128; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R10
    chk(reg_wr == 1'b0, "R10 wr idle", reg_wr, 0);
    chk(reg_rd == 1'b0, "R10 rd idle", reg_rd, 0);
    chk(miso_oe == 1'b0, "R10 oe idle", miso_oe, 0);
    frame(7'd5, 1'b0, 1, 0);       // R1 R2 single write
    frame(7'd20, 1'b0, 4, 0);      // R3 burst write
    frame(7'd126, 1'b0, 3, 0);     // R3 wrap
    frame(7'd40, 1'b0, 1, 9);      // R4 partial word dropped
    short_frame(5);                // R4 partial header dropped
    frame(7'd5, 1'b1, 1, 0);       // R5 R6 single read, R9
    frame(7'd20, 1'b1, 4, 0);      // R7 burst read
    frame(7'd127, 1'b1, 2, 0);     // R7 read across wrap
    frame(7'd40, 1'b1, 1, 0);      // R4 partial bits did not corrupt
    frame(7'd41, 1'b1, 1, 0);      // R4 neighbour untouched
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule